// File: doc/BRIEF.md
# Descriptor Condition Evaluator

This block decides, once per descriptor, whether the channel sequencer should raise an interrupt, take a branch and wait. Each of the three decisions has its own two-bit policy field in the descriptor's command word and its own condition bit. The condition bit comes from the channel's device status byte, filtered through a programmable select word for that decision.

A select word carries an eight-bit mask and an eight-bit compare value. The condition is true when the status byte, restricted to the mask bits, matches the compare value restricted to the same bits. An all-zero mask therefore makes the condition true. The sequencer pulses `evalStrobe` when the descriptor's data phase is over. One cycle later the three decisions appear together with `decValid`. The block also keeps a branch-taken flag that records the outcome of the most recent evaluation.

Top module: `desc_cond_eval`

## Requirements
- R1: While reset is held and right after it, `decValid`, `raiseIrq`, `takeBranch`, `holdWait` and `branchFlag` are all 0.
- R2: The interrupt policy is `cmdWord[5:4]`. Code 0 means never, 1 means when its condition is 1, 2 means when its condition is 0, and 3 means always.
- R3: The branch policy is `cmdWord[3:2]` and uses the same four codes as R2.
- R4: The wait policy is `cmdWord[1:0]` and uses the same four codes as R2.
- R5: A condition is 1 exactly when `(devStatus & sel[23:16]) == (sel[7:0] & sel[23:16])`. All other select bits have no effect.
- R6: A select word whose mask bits `[23:16]` are all zero gives a condition of 1 for every status byte and compare value.
- R7: The interrupt condition comes only from `intSel`, the branch condition only from `brSel`, and the wait condition only from `waitSel`.
- R8: An `evalStrobe` sampled at a clock edge makes `decValid` and the three decisions appear after the next edge. They last exactly one cycle unless another strobe follows. When `decValid` is 0, all three decisions are 0.
- R9: `branchFlag` is loaded with the branch decision at each evaluation and holds that value until the next evaluation.
- R10: Changes on `cmdWord`, `devStatus` or the select words while `evalStrobe` is low do not change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evalStrobe | input | 1 | Data phase over; evaluate this descriptor now |
| cmdWord | input | 16 | Descriptor command word; policy fields in bits 5:0 |
| devStatus | input | 8 | Channel device status byte |
| intSel | input | 32 | Interrupt select: mask 23:16, compare 7:0 |
| brSel | input | 32 | Branch select: mask 23:16, compare 7:0 |
| waitSel | input | 32 | Wait select: mask 23:16, compare 7:0 |
| decValid | output | 1 | Decisions valid this cycle |
| raiseIrq | output | 1 | Interrupt decision |
| takeBranch | output | 1 | Branch decision |
| holdWait | output | 1 | Wait decision |
| branchFlag | output | 1 | Branch outcome of the last evaluation |

## Verification
The bench runs all four policy codes in all three fields against both condition values. A design that swapped the if-set and if-clear codes, or read a field at the wrong bit offset, would produce inverted or cross-wired decisions. Three further cases are checked. Masks that cover only part of the byte catch a design that compares bits outside the mask. A zero mask paired with a nonzero compare value catches a design that does not treat the empty mask as always true. Different select words for each decision expose any sharing of select words between decisions. The bench also changes inputs between evaluations and confirms the pulses end after one cycle. A design that was transparent instead of sampling on the strobe, or that let the branch flag drift with the inputs, would fail there.

// File: rtl/desc_cond_pkg.sv
package desc_cond_pkg;
  localparam int CMD_W    = 16;
  localparam int STAT_W   = 8;
  localparam int SEL_W    = 32;
  localparam int MASK_LSB = 16;
  localparam int CMP_LSB  = 0;
  localparam int N_POL    = 3;          // 0 interrupt, 1 branch, 2 wait
  localparam int POL_W    = 2;

  typedef enum logic [POL_W-1:0] {
    POL_NEVER  = 2'd0,
    POL_IFSET  = 2'd1,
    POL_IFCLR  = 2'd2,
    POL_ALWAYS = 2'd3
  } policy_e;

  typedef struct packed {
    logic capture;   // sample decisions now
    logic expire;    // retire the one-cycle decision pulse
  } evalStrobes_t;

  function automatic int fieldLsb(input int idx);
    case (idx)
      0:       fieldLsb = 4;
      1:       fieldLsb = 2;
      default: fieldLsb = 0;
    endcase
  endfunction
endpackage

// File: rtl/desc_cond_ctrl.sv
module desc_cond_ctrl
  import desc_cond_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evalStrobe,
  output evalStrobes_t strobes,
  output logic         decValid
);
  always_ff @(posedge clk) begin
    if (!rst_n) decValid <= 1'b0;
    else        decValid <= evalStrobe;
  end

  always_comb begin
    strobes.capture = evalStrobe;
    strobes.expire  = decValid && !evalStrobe;
  end
endmodule

// File: rtl/desc_cond_dp.sv
module desc_cond_dp
  import desc_cond_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  evalStrobes_t                strobes,
  input  logic [CMD_W-1:0]            cmdWord,
  input  logic [STAT_W-1:0]           devStatus,
  input  logic [N_POL-1:0][SEL_W-1:0] selBus,
  output logic [N_POL-1:0]            decisions,
  output logic                        branchFlag
);
  logic [N_POL-1:0] condBit;
  logic [N_POL-1:0] decNext;

  for (genvar k = 0; k < N_POL; k++) begin : g_pol
    localparam int LSB = fieldLsb(k);
    logic [STAT_W-1:0] maskV;
    logic [STAT_W-1:0] cmpV;
    policy_e           pol;
    assign maskV = selBus[k][MASK_LSB +: STAT_W];
    assign cmpV  = selBus[k][CMP_LSB +: STAT_W];
    assign pol   = policy_e'(cmdWord[LSB +: POL_W]);
    assign condBit[k] = ((devStatus ^ cmpV) & maskV) == '0;
    always_comb begin
      case (pol)
        POL_NEVER:  decNext[k] = 1'b0;
        POL_IFSET:  decNext[k] = condBit[k];
        POL_IFCLR:  decNext[k] = !condBit[k];
        default:    decNext[k] = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      decisions  <= '0;
      branchFlag <= 1'b0;
    end else if (strobes.capture) begin
      decisions  <= decNext;
      branchFlag <= decNext[1];
    end else if (strobes.expire) begin
      decisions  <= '0;
    end
  end
endmodule

// File: rtl/desc_cond_eval.sv
module desc_cond_eval
  import desc_cond_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evalStrobe,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic [STAT_W-1:0] devStatus,
  input  logic [SEL_W-1:0]  intSel,
  input  logic [SEL_W-1:0]  brSel,
  input  logic [SEL_W-1:0]  waitSel,
  output logic              decValid,
  output logic              raiseIrq,
  output logic              takeBranch,
  output logic              holdWait,
  output logic              branchFlag
);
  evalStrobes_t                strobes;
  logic [N_POL-1:0]            decisions;
  logic [N_POL-1:0][SEL_W-1:0] selBus;

  assign selBus = {waitSel, brSel, intSel};

  desc_cond_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .evalStrobe(evalStrobe),
    .strobes(strobes), .decValid(decValid)
  );

  desc_cond_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .cmdWord(cmdWord),
    .devStatus(devStatus), .selBus(selBus), .decisions(decisions),
    .branchFlag(branchFlag)
  );

  assign raiseIrq   = decisions[0];
  assign takeBranch = decisions[1];
  assign holdWait   = decisions[2];
endmodule

// File: rtl/desc_cond_eval_chk.sv
module desc_cond_eval_chk
  import desc_cond_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             evalStrobe,
  input logic [CMD_W-1:0] cmdWord,
  input logic             decValid,
  input logic             raiseIrq,
  input logic             takeBranch,
  input logic             holdWait,
  input logic             branchFlag
);
  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evalStrobe |=> decValid);
  assert_valid_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !evalStrobe |=> !decValid);
  assert_quiet_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !decValid |-> !(raiseIrq || takeBranch || holdWait));
  assert_irq_never_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evalStrobe && cmdWord[5:4] == 2'd0) |=> !raiseIrq);
  assert_branch_always_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evalStrobe && cmdWord[3:2] == 2'd3) |=> takeBranch);
  assert_wait_always_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evalStrobe && cmdWord[1:0] == 2'd3) |=> holdWait);
  assert_flag_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    decValid |-> (branchFlag == takeBranch));
  assert_flag_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !evalStrobe |=> $stable(branchFlag));
endmodule

bind desc_cond_eval desc_cond_eval_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evalStrobe(evalStrobe), .cmdWord(cmdWord),
  .decValid(decValid), .raiseIrq(raiseIrq), .takeBranch(takeBranch),
  .holdWait(holdWait), .branchFlag(branchFlag)
);

// File: tb/desc_cond_eval_tb.sv
module desc_cond_eval_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evalStrobe = 1'b0;
  logic [15:0] cmdWord = '0;
  logic [7:0]  devStatus = '0;
  logic [31:0] intSel = '0, brSel = '0, waitSel = '0;
  logic        decValid, raiseIrq, takeBranch, holdWait, branchFlag;
  int          total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_cond_eval u_dut (
    .clk(clk), .rst_n(rst_n), .evalStrobe(evalStrobe), .cmdWord(cmdWord),
    .devStatus(devStatus), .intSel(intSel), .brSel(brSel), .waitSel(waitSel),
    .decValid(decValid), .raiseIrq(raiseIrq), .takeBranch(takeBranch),
    .holdWait(holdWait), .branchFlag(branchFlag)
  );

  function automatic logic condOf(input logic [31:0] sel, input logic [7:0] st);
    return (st & sel[23:16]) == (sel[7:0] & sel[23:16]);
  endfunction

  function automatic logic policy(input logic [1:0] code, input logic c);
    case (code)
      2'd0: return 1'b0;
      2'd1: return c;
      2'd2: return !c;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One evaluation: drive, strobe, check pulse, then check it retires.
  task automatic evaluate(input string req, input logic [15:0] cmd, input logic [7:0] st,
                          input logic [31:0] is, input logic [31:0] bs, input logic [31:0] ws);
    logic eI, eB, eW;
    eI = policy(cmd[5:4], condOf(is, st));
    eB = policy(cmd[3:2], condOf(bs, st));
    eW = policy(cmd[1:0], condOf(ws, st));
    @(negedge clk);
    cmdWord = cmd; devStatus = st; intSel = is; brSel = bs; waitSel = ws;
    evalStrobe = 1'b1;
    @(negedge clk);
    evalStrobe = 1'b0;
    check({req, " R8 valid"}, {31'd0, decValid}, 32'd1);
    check({req, " irq"}, {31'd0, raiseIrq}, {31'd0, eI});
    check({req, " branch"}, {31'd0, takeBranch}, {31'd0, eB});
    check({req, " wait"}, {31'd0, holdWait}, {31'd0, eW});
    check({req, " R9 flag"}, {31'd0, branchFlag}, {31'd0, eB});
    @(negedge clk);
    check({req, " R8 pulse end"}, {28'd0, decValid, raiseIrq, takeBranch, holdWait}, 32'd0);
    check({req, " R9 flag hold"}, {31'd0, branchFlag}, {31'd0, eB});
  endtask

  task automatic t_reset_R1();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", {27'd0, decValid, raiseIrq, takeBranch, holdWait, branchFlag}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {27'd0, decValid, raiseIrq, takeBranch, holdWait, branchFlag}, 32'd0);
  endtask

  task automatic t_codes_R2_R3_R4();
    // sel mask 0x01 compare 0x01: condition = status bit0
    for (int code = 0; code < 4; code++) begin
      for (int s = 0; s < 2; s++) begin
        evaluate("R2", 16'(code << 4), 8'(s), 32'h0001_0001, 32'h0001_0001, 32'h0001_0001);
        evaluate("R3", 16'(code << 2), 8'(s), 32'h0001_0001, 32'h0001_0001, 32'h0001_0001);
        evaluate("R4", 16'(code), 8'(s), 32'h0001_0001, 32'h0001_0001, 32'h0001_0001);
      end
    end
  endtask

  task automatic t_mask_R5();
    // mask F0 compare A5: only high nibble matters; other select bits junk
    evaluate("R5 match", 16'h0015, 8'hA3, 32'hFFF0_FFA5, 32'h00F0_00A5, 32'h00F0_00A5);
    evaluate("R5 miss", 16'h0015, 8'hB5, 32'h00F0_00A5, 32'h00F0_00A5, 32'h00F0_00A5);
    evaluate("R5 clr", 16'h002A, 8'h5A, 32'h00F0_00A5, 32'h00F0_00A5, 32'h00F0_00A5);
  endtask

  task automatic t_zero_mask_R6();
    evaluate("R6 zero mask", 16'h0015, 8'h3C, 32'h0000_00FF, 32'h0000_0081, 32'hFF00_0042);
    evaluate("R6 zero mask clr", 16'h002A, 8'hC3, 32'h0000_00FF, 32'h0000_0081, 32'hFF00_0042);
  endtask

  task automatic t_independent_R7();
    // all if-set; status 0x0F; only brSel matches
    evaluate("R7 branch only", 16'h0015, 8'h0F, 32'h00FF_0000, 32'h00FF_000F, 32'h00FF_00F0);
    evaluate("R7 wait only", 16'h0015, 8'hF0, 32'h00FF_0000, 32'h00FF_000F, 32'h00FF_00F0);
    evaluate("R7 irq only", 16'h0015, 8'h00, 32'h00FF_0000, 32'h00FF_000F, 32'h00FF_00F0);
  endtask

  task automatic t_ignore_R10();
    evaluate("R10 setup", 16'h000C, 8'h00, '0, '0, '0);   // branch taken, flag 1
    @(negedge clk);
    cmdWord = 16'h0000; devStatus = 8'hFF; intSel = 32'h00FF_0000;
    brSel = 32'h00FF_0000; waitSel = 32'h00FF_0000;
    repeat (3) @(negedge clk);
    check("R10 ignored", {27'd0, decValid, raiseIrq, takeBranch, holdWait, branchFlag}, 32'd1);
    evaluate("R9 overwrite", 16'h0000, 8'h00, '0, '0, '0);
  endtask

  initial begin
    fork
      begin
        t_reset_R1();
        t_codes_R2_R3_R4();
        t_mask_R5();
        t_zero_mask_R6();
        t_independent_R7();
        t_ignore_R10();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule